// File: doc/BRIEF.md
# Three-Level Maskable Interrupt Acceptance Controller

This block sits between a set of peripheral interrupt lines and a CPU core. It collects requests into pending bits, decides which pending source may be taken given the CPU's global mask and user mask, and raises a registered accept flag together with the vector number of the chosen source. Two inputs bypass the masks entirely: a non-maskable request and an address-break request.

A two-bit mode field selects how the masks act. In the simple mode only the global mask matters. In the three-level mode, a per-source control-level bit works with both masks, so the CPU can block everything, block only level-0 sources, or block nothing. Control level also sets precedence: level-1 sources beat level-0 sources. Among sources of equal standing, a fixed default order chooses the winner.

The accepted vector is held until the CPU pulses acknowledge. The acknowledge clears only the accepted source's pending bit, and every other request remains pending for a later turn.

Top module: `irq3_ctrl`

## Requirements
- R1: After reset, `acceptOut` is 0 and every bit of `pendView` is 0.
- R2: A request that is high at a clock edge sets its pending bit at that edge. The bit stays set after the request drops and is cleared only by acknowledge. A request that is still high at the acknowledging edge keeps its bit set.
- R3: The non-maskable and address-break requests are accepted whatever the mode, `maskI` and `maskUI`.
- R4: With `modeSel` = 00, `maskI` = 0 admits all peripheral sources and `maskI` = 1 blocks all of them, although their pending bits still set. The unused codes 10 and 11 behave like 00.
- R5: With `modeSel` = 01, `maskI` = 0 admits all peripheral sources. `maskI` = 1 with `maskUI` = 0 admits only sources whose `ctrlLevel` bit is 1. `maskI` = 1 with `maskUI` = 1 admits none.
- R6: Among admitted pending sources, the winner is chosen in this order: non-maskable first, then address break, then level-1 peripherals by ascending index, then level-0 peripherals by ascending index. The position is 0 for non-maskable, 1 for address break and 2+i for peripheral i, and `vecOut` = `VEC_BASE` + position.
- R7: `acceptOut` rises one clock edge after an admitted source is pending. While it is high, `acceptOut` and `vecOut` hold their values until acknowledged, even if a higher-priority request arrives.
- R8: An `ackPulse` seen at an edge while `acceptOut` is high clears the accepted source's pending bit and drops `acceptOut` at that edge, and leaves all other pending bits untouched. An `ackPulse` while `acceptOut` is low changes nothing.
- R9: `pendView` bit k is the pending bit of position k, using the numbering of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiReq | input | 1 | Non-maskable request, level |
| brkReq | input | 1 | Address-break request, level |
| srcReq | input | NUM_SRC | Peripheral requests, level |
| ctrlLevel | input | NUM_SRC | Per-source control level |
| modeSel | input | 2 | Interrupt control mode |
| maskI | input | 1 | Global mask bit |
| maskUI | input | 1 | User mask bit |
| ackPulse | input | 1 | Acknowledge of the accepted vector |
| acceptOut | output | 1 | An interrupt is accepted and awaits acknowledge |
| vecOut | output | VEC_W | Vector number of the accepted source |
| pendView | output | NUM_SRC+2 | Pending bits by position |

## Verification
The hardest case to reach is a set of several pending sources that spans both control levels and a bypass request at the same time, while a previously accepted vector is still being held. The bench gets there by pulsing several requests in a single cycle, or by pulsing a non-maskable request during a hold. It then acknowledges one vector at a time and checks the winner order and the surviving pending bits after each acknowledge. A second hard case is a request line that stays high across its own acknowledge. The bench holds a line high through the acknowledge and expects the source to be accepted again.

// File: rtl/irq3_pkg.sv
package irq3_pkg;

  // Strobes issued by the acceptance control to the datapath
  typedef struct packed {
    logic latchSel;   // capture the current winner and its vector
    logic clearSel;   // clear the pending bit of the held winner
  } irq3Strobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } irq3State_t;

endpackage

// File: rtl/irq3_datapath.sv
module irq3_datapath
  import irq3_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nmiReq,
  input  logic                 brkReq,
  input  logic [NUM_SRC-1:0]   srcReq,
  input  logic [NUM_SRC-1:0]   ctrlLevel,
  input  logic [1:0]           modeSel,
  input  logic                 maskI,
  input  logic                 maskUI,
  input  irq3Strobe_t          strobe,
  output logic                 anyWin,
  output logic [VEC_W-1:0]     vecOut,
  output logic [NUM_SRC+1:0]   pendView
);

  localparam int NUM_POS = NUM_SRC + 2;
  localparam int POS_W   = $clog2(NUM_POS);

  logic [NUM_POS-1:0] reqAll;
  logic [NUM_POS-1:0] pendQ;
  logic [NUM_POS-1:0] clearMask;
  logic [NUM_SRC-1:0] srcOk;
  logic [NUM_SRC-1:0] hiCand;
  logic [NUM_SRC-1:0] loCand;
  logic [NUM_SRC-1:0] srcPend;
  logic [POS_W-1:0]   winPos;
  logic [POS_W-1:0]   selQ;
  logic [VEC_W-1:0]   vecQ;
  logic               modeOne;

  assign reqAll  = {srcReq, brkReq, nmiReq};
  assign srcPend = pendQ[NUM_POS-1:2];
  assign modeOne = (modeSel == 2'b01);

  // Per-source mask decision: the level bit only opens a source in mode 01
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_srcMask
    assign srcOk[i]  = !maskI || (modeOne && !maskUI && ctrlLevel[i]);
    assign hiCand[i] = srcPend[i] && srcOk[i] && ctrlLevel[i];
    assign loCand[i] = srcPend[i] && srcOk[i] && !ctrlLevel[i];
  end

  // Fixed-order pick: later assignments override earlier, lowest index last
  always_comb begin
    anyWin = 1'b0;
    winPos = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (loCand[i]) begin
        anyWin = 1'b1;
        winPos = POS_W'(i + 2);
      end
    end
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hiCand[i]) begin
        anyWin = 1'b1;
        winPos = POS_W'(i + 2);
      end
    end
    if (pendQ[1]) begin
      anyWin = 1'b1;
      winPos = POS_W'(1);
    end
    if (pendQ[0]) begin
      anyWin = 1'b1;
      winPos = '0;
    end
  end

  assign clearMask = strobe.clearSel ? (NUM_POS'(1) << selQ) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      selQ  <= '0;
      vecQ  <= '0;
    end else begin
      pendQ <= (pendQ & ~clearMask) | reqAll;
      if (strobe.latchSel) begin
        selQ <= winPos;
        vecQ <= VEC_W'(VEC_BASE) + VEC_W'(winPos);
      end
    end
  end

  assign vecOut   = vecQ;
  assign pendView = pendQ;

  // Assertions
  assert_bypass_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ[1:0] != 2'b00) |-> anyWin);

  assert_mode0_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!modeOne && maskI && pendQ[1:0] == 2'b00) |-> !anyWin);

  assert_winner_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchSel |-> pendQ[winPos]);

  assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchSel |=> $stable(vecQ));

  assert_clear_sel_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearSel && !reqAll[selQ]) |=> !pendQ[$past(selQ)]);

  assert_losers_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearSel |=>
      (($past(pendQ) & ~(NUM_POS'(1) << $past(selQ)) & ~pendQ) == '0));

endmodule

// File: rtl/irq3_control.sv
module irq3_control
  import irq3_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyWin,
  input  logic        ackPulse,
  output irq3Strobe_t strobe,
  output logic        acceptOut
);

  irq3State_t stateQ;
  irq3State_t stateD;

  always_comb begin
    stateD          = stateQ;
    strobe.latchSel = 1'b0;
    strobe.clearSel = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (anyWin) begin
          strobe.latchSel = 1'b1;
          stateD          = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (ackPulse) begin
          strobe.clearSel = 1'b1;
          stateD          = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign acceptOut = (stateQ == ST_HOLD);

  // Assertions
  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (acceptOut && !ackPulse) |=> acceptOut);

  assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
    (acceptOut && ackPulse) |=> !acceptOut);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.latchSel && strobe.clearSel));

endmodule

// File: rtl/irq3_ctrl.sv
module irq3_ctrl
  import irq3_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiReq,
  input  logic               brkReq,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] ctrlLevel,
  input  logic [1:0]         modeSel,
  input  logic               maskI,
  input  logic               maskUI,
  input  logic               ackPulse,
  output logic               acceptOut,
  output logic [VEC_W-1:0]   vecOut,
  output logic [NUM_SRC+1:0] pendView
);

  irq3Strobe_t strobe;
  logic        anyWin;

  irq3_datapath #(
    .NUM_SRC  (NUM_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .nmiReq    (nmiReq),
    .brkReq    (brkReq),
    .srcReq    (srcReq),
    .ctrlLevel (ctrlLevel),
    .modeSel   (modeSel),
    .maskI     (maskI),
    .maskUI    (maskUI),
    .strobe    (strobe),
    .anyWin    (anyWin),
    .vecOut    (vecOut),
    .pendView  (pendView)
  );

  irq3_control ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .anyWin    (anyWin),
    .ackPulse  (ackPulse),
    .strobe    (strobe),
    .acceptOut (acceptOut)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!acceptOut && pendView == '0));

endmodule

// File: tb/irq3_ctrl_tb.sv
module irq3_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          nmiReq, brkReq, maskI, maskUI, ackPulse;
  logic [NS-1:0] srcReq, ctrlLevel;
  logic [1:0]    modeSel;
  logic          acceptOut;
  logic [7:0]    vecOut;
  logic [NS+1:0] pendView;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq3_ctrl #(.NUM_SRC(NS), .VEC_W(8), .VEC_BASE(16)) dut_i (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .brkReq(brkReq),
    .srcReq(srcReq), .ctrlLevel(ctrlLevel), .modeSel(modeSel),
    .maskI(maskI), .maskUI(maskUI), .ackPulse(ackPulse),
    .acceptOut(acceptOut), .vecOut(vecOut), .pendView(pendView)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // Drive requests for exactly one edge; returns at the negedge after it
  task automatic reqPulse(input logic n, input logic b, input logic [NS-1:0] s);
    nmiReq = n; brkReq = b; srcReq = s;
    step();
    nmiReq = 1'b0; brkReq = 1'b0; srcReq = '0;
  endtask

  task automatic doAck();
    ackPulse = 1'b1;
    step();
    ackPulse = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 accept after reset", 32'(acceptOut), 0);
    chk("R1 pending after reset", 32'(pendView), 0);
  endtask

  task automatic tBypass();
    modeSel = 2'b01; maskI = 1'b1; maskUI = 1'b1;
    reqPulse(1'b1, 1'b0, '0);
    chk("R9 nmi pending at bit0", 32'(pendView), 32'h1);
    chk("R7 no accept before next edge", 32'(acceptOut), 0);
    step();
    chk("R3 nmi accepted under masks", 32'(acceptOut), 1);
    chk("R6 nmi vector", 32'(vecOut), 16);
    doAck();
    chk("R8 accept drops on ack", 32'(acceptOut), 0);
    chk("R8 nmi pending cleared", 32'(pendView), 0);
    reqPulse(1'b0, 1'b1, '0);
    step();
    chk("R3 break accepted under masks", 32'(acceptOut), 1);
    chk("R6 break vector", 32'(vecOut), 17);
    doAck();
    chk("R8 break pending cleared", 32'(pendView), 0);
  endtask

  task automatic tMode0();
    modeSel = 2'b00; maskI = 1'b1; maskUI = 1'b0; ctrlLevel = '1;
    reqPulse(1'b0, 1'b0, NS'(1) << 3);
    step(3);
    chk("R4 mode0 I=1 blocks", 32'(acceptOut), 0);
    chk("R2 blocked request held pending", 32'(pendView), 32'h20);
    maskI = 1'b0;
    step();
    chk("R4 mode0 I=0 accepts", 32'(acceptOut), 1);
    chk("R6 src3 vector", 32'(vecOut), 21);
    doAck();
    chk("R8 src3 cleared", 32'(pendView), 0);
  endtask

  task automatic tMode1();
    modeSel = 2'b01; maskI = 1'b1; maskUI = 1'b0; ctrlLevel = NS'(1) << 4;
    reqPulse(1'b0, 1'b0, (NS'(1) << 2) | (NS'(1) << 4));
    chk("R2 two pending", 32'(pendView), 32'h50);
    step();
    chk("R5 level1 admitted I=1 UI=0", 32'(vecOut), 22);
    doAck();
    chk("R8 level0 loser kept", 32'(pendView), 32'h10);
    step(2);
    chk("R5 level0 blocked I=1 UI=0", 32'(acceptOut), 0);
    maskUI = 1'b1;
    step(2);
    chk("R5 blocked I=1 UI=1", 32'(acceptOut), 0);
    maskI = 1'b0;
    step();
    chk("R5 I=0 admits level0", 32'(vecOut), 20);
    doAck();
    maskI = 1'b1; maskUI = 1'b1;
    reqPulse(1'b0, 1'b0, NS'(1) << 4);
    step(2);
    chk("R5 level1 blocked I=1 UI=1", 32'(acceptOut), 0);
    maskUI = 1'b0;
    step();
    chk("R5 level1 admitted after UI clear", 32'(vecOut), 22);
    doAck();
    chk("R8 all clear", 32'(pendView), 0);
  endtask

  task automatic tPriority();
    modeSel = 2'b01; maskI = 1'b0; maskUI = 1'b0; ctrlLevel = NS'(1) << 9;
    reqPulse(1'b0, 1'b1, (NS'(1) << 1) | (NS'(1) << 9) | (NS'(1) << 5));
    step();
    chk("R6 break beats peripherals", 32'(vecOut), 17);
    doAck();
    chk("R8 losers stay pending", 32'(pendView), 32'h888);
    step();
    chk("R6 level1 src9 beats level0", 32'(vecOut), 27);
    doAck();
    step();
    chk("R6 src1 before src5", 32'(vecOut), 19);
    doAck();
    step();
    chk("R6 src5 last", 32'(vecOut), 23);
    doAck();
    chk("R8 queue drained", 32'(pendView), 0);
  endtask

  task automatic tHold();
    modeSel = 2'b01; maskI = 1'b0; ctrlLevel = '0;
    reqPulse(1'b0, 1'b0, NS'(1) << 6);
    step();
    chk("R6 src6 vector", 32'(vecOut), 24);
    reqPulse(1'b1, 1'b0, '0);
    step(2);
    chk("R7 accept held", 32'(acceptOut), 1);
    chk("R7 vector not preempted", 32'(vecOut), 24);
    doAck();
    chk("R8 nmi still pending", 32'(pendView), 32'h1);
    step();
    chk("R6 nmi next", 32'(vecOut), 16);
    doAck();
  endtask

  task automatic tAckIdle();
    modeSel = 2'b00; maskI = 1'b1;
    reqPulse(1'b0, 1'b0, NS'(1));
    doAck();
    chk("R8 idle ack ignored", 32'(pendView), 32'h4);
    chk("R8 idle ack no accept", 32'(acceptOut), 0);
    maskI = 1'b0;
    step();
    chk("R6 src0 vector", 32'(vecOut), 18);
    doAck();
  endtask

  task automatic tUnusedMode();
    modeSel = 2'b11; maskI = 1'b1; maskUI = 1'b0; ctrlLevel = NS'(1) << 7;
    reqPulse(1'b0, 1'b0, NS'(1) << 7);
    step(2);
    chk("R4 code 11 acts as mode 00", 32'(acceptOut), 0);
    maskI = 1'b0;
    step();
    chk("R4 code 11 I=0 accepts", 32'(vecOut), 25);
    doAck();
  endtask

  task automatic tHeldReq();
    modeSel = 2'b01; maskI = 1'b0; ctrlLevel = '0;
    srcReq = NS'(1) << 12;
    step(2);
    chk("R2 level request accepted", 32'(vecOut), 30);
    doAck();
    chk("R2 held request re-pends", 32'(pendView), 32'h4000);
    chk("R8 accept dropped", 32'(acceptOut), 0);
    step();
    chk("R2 accepted again", 32'(acceptOut), 1);
    srcReq = '0;
    doAck();
    chk("R8 released source cleared", 32'(pendView), 0);
  endtask

  initial begin
    rstN = 1'b0; nmiReq = 0; brkReq = 0; srcReq = '0; ctrlLevel = '0;
    modeSel = 2'b00; maskI = 1'b0; maskUI = 1'b0; ackPulse = 1'b0;
    step(3);
    rstN = 1'b1;
    tReset();
    tBypass();
    tMode0();
    tMode1();
    tPriority();
    tHold();
    tAckIdle();
    tUnusedMode();
    tHeldReq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

endmodule